// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates a set of interrupt request lines for a single processor and lets their servicing nest. Each source has a two-bit programmable urgency level, where level 0 is the most urgent. Each source also has a fixed rank given by its index, and the lower index ranks higher. A rising edge on a request line sets that source's pending flag. The combinational arbiter picks the pending source with the most urgent level and breaks ties by the lower index. That winner is acknowledged only when acceptance is enabled and its level is strictly more urgent than every level already in service.

An acknowledge records the winner's level in a stack that holds one bit per level. It also clears the source's pending flag and disables further acceptance. The processor re-enables acceptance with an explicit strobe when it is ready to allow nesting. An end-of-service strobe retires the most urgent level in the stack and re-enables acceptance. At that point the pending requests that were held back are considered again, one at a time, in priority order.

Top module: `nic_top`

## Requirements
- R1: After reset no acknowledge is issued, all pending and in-service flags are clear, and acceptance is disabled.
- R2: A 0-to-1 transition on `irq_i[s]` sets `pend_o[s]` one clock later. The flag clears in the same cycle in which `ack_o` is high with `ack_id_o == s`.
- R3: A request is acknowledged only while acceptance is enabled. An acknowledge disables acceptance. `en_set_i` enables acceptance, and `en_clr_i` disables it and wins if both strobes arrive together.
- R4: A pending request whose level is numerically lower than the most urgent in-service level is acknowledged while that service is still open. Its level bit is then added to `isv_lvl_o`, so that bit L of `isv_lvl_o` marks level L in service.
- R5: A pending request whose level is equal to, or numerically greater than, the most urgent in-service level stays pending without acknowledge, even while acceptance is enabled.
- R6: Among pending requests, the one with the numerically lowest level is acknowledged first, regardless of arrival order. The level of source s is `lvl_i[2*s+1:2*s]`.
- R7: Among pending requests at the same level, the lowest source index is acknowledged first, regardless of arrival order.
- R8: `eos_i` clears the lowest set bit of `isv_lvl_o`, clears the `isv_src_o` bit of the source that was accepted at that level, and enables acceptance. When no level is in service, `eos_i` changes nothing.
- R9: Each acknowledge is a single-cycle pulse on `ack_o`, and `ack_id_o` carries the winning source index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | N | Request lines; rising edge requests service |
| lvl_i | input | N*LW | Per-source urgency level, source s in bits [s*LW +: LW] |
| en_set_i | input | 1 | Enable acceptance strobe |
| en_clr_i | input | 1 | Disable acceptance strobe (dominant) |
| eos_i | input | 1 | End-of-service strobe |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_id_o | output | IW | Index of the acknowledged source |
| pend_o | output | N | Per-source pending flags |
| isv_src_o | output | N | Per-source in-service flags |
| isv_lvl_o | output | 2**LW | Per-level in-service stack |

## Verification
A request edge driven before clock edge k shows up in `pend_o` after edge k. When acceptance is already enabled, its acknowledge arrives after edge k+1. An enable or end-of-service strobe sampled at edge k changes the stack at that edge and, when a request qualifies, produces the acknowledge at edge k+1. The bench drives inputs just after the falling edge and waits three falling edges before it reads status, so every result it checks has settled. A monitor pops the expected identity of each acknowledge from a queue at every falling edge. Any acknowledge that was not expected, or any acknowledge held high for two samples, is therefore reported.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int unsigned NIC_SRC_DEF   = 8;
    localparam int unsigned NIC_LVL_W_DEF = 2;
endpackage

// File: rtl/nic_edge.sv
module nic_edge #(
    parameter int unsigned N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] irq_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] irq_d, irq_q;

    always_comb begin
        irq_d  = irq_i;
        rise_o = irq_i & ~irq_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= irq_d;
    end
endmodule

// File: rtl/nic_arb.sv
module nic_arb #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = 2,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    pend_i,
    input  logic [N*LW-1:0] lvl_i,
    output logic            win_vld_o,
    output logic [IW-1:0]   win_id_o,
    output logic [LW-1:0]   win_lvl_o
);
    always_comb begin
        win_vld_o = 1'b0;
        win_id_o  = '0;
        win_lvl_o = '1;
        // Descending scan with <= lets the lower index win a tie.
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i] && (!win_vld_o || lvl_i[i*LW +: LW] <= win_lvl_o)) begin
                win_vld_o = 1'b1;
                win_id_o  = IW'(i);
                win_lvl_o = lvl_i[i*LW +: LW];
            end
        end
    end
endmodule

// File: rtl/nic_stack_top.sv
module nic_stack_top #(
    parameter int unsigned LW = 2,
    localparam int unsigned NL = 1 << LW
) (
    input  logic [NL-1:0] isv_i,
    output logic          top_vld_o,
    output logic [LW-1:0] top_lvl_o
);
    always_comb begin
        top_vld_o = 1'b0;
        top_lvl_o = '0;
        for (int j = NL - 1; j >= 0; j--) begin
            if (isv_i[j]) begin
                top_vld_o = 1'b1;
                top_lvl_o = LW'(j);
            end
        end
    end
endmodule

// File: rtl/nic_top.sv
module nic_top
    import nic_pkg::*;
#(
    parameter int unsigned N  = NIC_SRC_DEF,
    parameter int unsigned LW = NIC_LVL_W_DEF,
    localparam int unsigned NL = 1 << LW,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N-1:0]    irq_i,
    input  logic [N*LW-1:0] lvl_i,
    input  logic            en_set_i,
    input  logic            en_clr_i,
    input  logic            eos_i,
    output logic            ack_o,
    output logic [IW-1:0]   ack_id_o,
    output logic [N-1:0]    pend_o,
    output logic [N-1:0]    isv_src_o,
    output logic [NL-1:0]   isv_lvl_o
);
    typedef struct packed {
        logic [N-1:0]           pend;
        logic [N-1:0]           isv_src;
        logic [NL-1:0]          isv_lvl;
        logic [NL-1:0][IW-1:0]  owner;
        logic                   en;
        logic                   ack;
        logic [IW-1:0]          ack_id;
    } nic_state_t;

    nic_state_t s_d, s_q;

    logic [N-1:0]  rise;
    logic          win_vld;
    logic [IW-1:0] win_id;
    logic [LW-1:0] win_lvl;
    logic          top_vld;
    logic [LW-1:0] top_lvl;
    logic          grant;
    logic          en_w;

    nic_edge #(.N(N)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i),
        .rise_o (rise)
    );

    nic_arb #(.N(N), .LW(LW)) u_arb (
        .pend_i    (s_q.pend),
        .lvl_i     (lvl_i),
        .win_vld_o (win_vld),
        .win_id_o  (win_id),
        .win_lvl_o (win_lvl)
    );

    nic_stack_top #(.LW(LW)) u_top (
        .isv_i     (s_q.isv_lvl),
        .top_vld_o (top_vld),
        .top_lvl_o (top_lvl)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        grant   = win_vld && s_q.en && (!top_vld || (win_lvl < top_lvl));

        if (eos_i && top_vld) begin
            s_d.isv_lvl[top_lvl]            = 1'b0;
            s_d.isv_src[s_q.owner[top_lvl]] = 1'b0;
            s_d.en                          = 1'b1;
        end
        if (en_set_i) s_d.en = 1'b1;
        if (en_clr_i) s_d.en = 1'b0;

        if (grant) begin
            s_d.pend[win_id]     = 1'b0;
            s_d.isv_lvl[win_lvl] = 1'b1;
            s_d.isv_src[win_id]  = 1'b1;
            s_d.owner[win_lvl]   = win_id;
            s_d.en               = 1'b0;
            s_d.ack              = 1'b1;
            s_d.ack_id           = win_id;
        end
        s_d.pend = s_d.pend | rise;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign en_w      = s_q.en;
    assign ack_o     = s_q.ack;
    assign ack_id_o  = s_q.ack_id;
    assign pend_o    = s_q.pend;
    assign isv_src_o = s_q.isv_src;
    assign isv_lvl_o = s_q.isv_lvl;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = 2,
    localparam int unsigned NL = 1 << LW,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          eos_i,
    input logic          ack_o,
    input logic [IW-1:0] ack_id_o,
    input logic [N-1:0]  isv_src_o,
    input logic [NL-1:0] isv_lvl_o,
    input logic          en_w
);
    assert_ack_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    assert_ack_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> ($past(en_w) && !en_w));

    assert_ack_in_service_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> isv_src_o[ack_id_o]);

    assert_nest_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && !$past(eos_i)) |->
            ($countones(isv_lvl_o) == $countones($past(isv_lvl_o)) + 1));

    assert_stack_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(isv_src_o) == $countones(isv_lvl_o));
endmodule

bind nic_top nic_chk #(.N(N), .LW(LW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eos_i     (eos_i),
    .ack_o     (ack_o),
    .ack_id_o  (ack_id_o),
    .isv_src_o (isv_src_o),
    .isv_lvl_o (isv_lvl_o),
    .en_w      (en_w)
);

// File: tb/tb_nic_top.sv
module tb_nic_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int LW = 2;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq = '0;
    logic [N*LW-1:0] lvl = '0;
    logic            en_set = 1'b0, en_clr = 1'b0, eos = 1'b0;
    logic            ack;
    logic [IW-1:0]   ack_id;
    logic [N-1:0]    pend, isv_src;
    logic [3:0]      isv_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int exp_q[$];
    bit prev_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_top #(.N(N), .LW(LW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .lvl_i(lvl),
        .en_set_i(en_set), .en_clr_i(en_clr), .eos_i(eos),
        .ack_o(ack), .ack_id_o(ack_id), .pend_o(pend),
        .isv_src_o(isv_src), .isv_lvl_o(isv_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(input int s);
        irq[s] = 1'b1; tick(1); irq[s] = 1'b0;
    endtask

    task automatic do_set();  en_set = 1'b1; tick(1); en_set = 1'b0; endtask
    task automatic do_clr();  en_clr = 1'b1; tick(1); en_clr = 1'b0; endtask
    task automatic do_eos();  eos    = 1'b1; tick(1); eos    = 1'b0; endtask

    // Monitor: pops expected acknowledges (R9), flags unexpected or stretched ones.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack) begin
                if (prev_ack) chk("R9 ack width", 2, 1);
                if (exp_q.size() == 0) chk("R3/R5 unexpected ack id", int'(ack_id), -1);
                else chk("R9 ack id", int'(ack_id), exp_q.pop_front());
            end
            prev_ack = ack;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // Levels: s0:3 s1:3 s2:1 s3:3 s4:1 s5:0 s6:2 s7:3
        lvl = {2'd3, 2'd2, 2'd0, 2'd1, 2'd3, 2'd1, 2'd3, 2'd3};
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 ack", int'(ack), 0);
        chk("R1 pend", int'(pend), 0);
        chk("R1 isv_lvl", int'(isv_lvl), 0);

        // Disabled after reset: request held (R1, R2)
        pulse_irq(2); tick(3);
        chk("R1 pend held while disabled", int'(pend), 'h04);
        exp_q.push_back(2); do_set(); tick(3);
        chk("R2 pend cleared by ack", int'(pend), 0);
        chk("R4 isv_lvl after first ack", int'(isv_lvl), 'b0010);
        chk("R4 isv_src after first ack", int'(isv_src), 'h04);

        // Acceptance disabled after an ack (R3)
        irq[5] = 1'b1; irq[6] = 1'b1; tick(1); irq = '0; tick(3);
        chk("R3 requests held after ack", int'(pend), 'h60);
        exp_q.push_back(5); do_set(); tick(3);
        chk("R4 nested stack", int'(isv_lvl), 'b0011);
        chk("R2 pend after nested ack", int'(pend), 'h40);

        // Less urgent request held though enabled (R5)
        do_set(); tick(3);
        chk("R5 lower level held", int'(pend), 'h40);
        do_eos(); tick(3);
        chk("R8 eos pops level 0", int'(isv_lvl), 'b0010);
        chk("R8 eos clears source 5", int'(isv_src), 'h04);
        chk("R5 still held under level 1", int'(pend), 'h40);
        exp_q.push_back(6); do_eos(); tick(3);
        chk("R8 eos then held request acked", int'(isv_lvl), 'b0100);
        chk("R8 isv_src holds source 6", int'(isv_src), 'h40);
        do_eos(); tick(3);
        chk("R8 stack empty", int'(isv_lvl), 0);

        // Tie at same level: lower index wins over earlier arrival (R7)
        do_clr();
        pulse_irq(7); tick(1); pulse_irq(3); tick(2);
        chk("R7 both pending", int'(pend), 'h88);
        exp_q.push_back(3); do_set(); tick(3);
        chk("R7 lower index in service", int'(isv_src), 'h08);
        do_set(); tick(3);
        chk("R5 equal level held", int'(pend), 'h80);
        exp_q.push_back(7); do_eos(); tick(3);
        chk("R8 next tied request", int'(isv_src), 'h80);
        do_eos(); tick(3);

        // Urgency beats arrival order (R6)
        do_clr();
        pulse_irq(0); tick(1); pulse_irq(4); tick(2);
        exp_q.push_back(4); do_set(); tick(3);
        chk("R6 urgent late arrival first", int'(isv_src), 'h10);
        exp_q.push_back(0); do_eos(); tick(3);
        chk("R6 earlier request follows", int'(isv_src), 'h01);
        chk("R6 stack level 3", int'(isv_lvl), 'b1000);
        do_eos(); tick(3);

        // eos with empty stack changes nothing (R8), en_clr dominant (R3)
        en_set = 1'b1; en_clr = 1'b1; tick(1); en_set = 1'b0; en_clr = 1'b0;
        do_eos(); pulse_irq(2); tick(3);
        chk("R8 empty eos no enable", int'(pend), 'h04);
        chk("R8 empty eos stack", int'(isv_lvl), 0);
        exp_q.push_back(2); do_set(); tick(3);
        chk("R4 accept after enable", int'(isv_lvl), 'b0010);
        do_eos(); tick(3);

        chk("R9 all expected acks seen", exp_q.size(), 0);
        finish_run();
    end
endmodule